// File: doc/BRIEF.md
# Bit-Reversed Bus Cartridge Mapper

This block is the cartridge-side glue for a board that pairs a small six-bit accumulator chip with program ROM, character ROM and the console's internal nametable RAM. The CPU data lines reach the chip in reverse order, so every value crossing between the CPU bus and the chip has its bit order flipped. The block decodes a register window in the low CPU space, applies the swapped data to the chip's staging, mode, invert and accumulator registers, and forwards every write in the upper half of the CPU space to the chip. That write copies the accumulator into an output latch. The latch selects an 8 KiB character bank. The invert flag also selects the nametable mirroring.

Each CPU cycle is sorted into one named access class by the decoder: `ACC_IDLE`, `ACC_REG_WRITE`, `ACC_REG_READ`, `ACC_ROM_WRITE`, `ACC_ROM_READ`, `ACC_OPEN_READ` and `ACC_DROP_WRITE`. A write takes priority over a read when both strobes are set. A register write becomes one chip command, chosen by CPU address bits 1:0: `CMD_STEP` (0), `CMD_SET_INV` (1), `CMD_STAGE` (2) or `CMD_SET_MODE` (3). An `ACC_ROM_WRITE` becomes `CMD_LATCH`. Every other class becomes `CMD_NONE`. A command is applied on the clock edge that ends its cycle, and from then on the stored state feeds the combinational outputs.

Top module: `revbus_mapper`

## Requirements
- R1: A CPU access lies in the register window exactly when (address AND 0xE100) equals 0x4100. Address bits 1:0 select the sub-register, so 0x5F02 acts the same as 0x4102.
- R2: Chip data bit k is CPU data bit 5-k for k = 0..5. CPU data bits 7:6 have no effect on any register.
- R3: A write to sub-register 0 while increment mode is off loads the accumulator low nibble with the staged nibble, XORed with 0xF when invert is 1.
- R4: A write to sub-register 0 while increment mode is on adds one to the accumulator low nibble, wrapping from 15 to 0. The accumulator high pair is left unchanged.
- R5: A write to sub-register 2 sets the accumulator high pair from chip bits 5:4 and the staged nibble from chip bits 3:0. Sub-register 1 sets invert and sub-register 3 sets increment mode, each from chip bit 0.
- R6: A register-window read returns CPU bits 7:6 from the open-bus input. CPU bits 5:0 hold the bit reversal of the six-bit value {high pair XOR (invert ? 3 : 0), low nibble}.
- R7: A write at 0x8000 or above loads the output latch with {high pair XOR (invert ? 3 : 0), low nibble}. No other access changes the latch.
- R8: A read at 0x8000 or above asserts the program ROM enable, puts CPU address bits 14:0 on the program ROM address and returns the ROM data. A read below 0x8000 outside the window returns the open-bus value. The program ROM enable never rises for writes.
- R9: The character ROM address is {latch bits 1:0, PPU address bits 12:0}. The character ROM enable follows PPU reads with PPU A13 clear. PPU writes to that range are ignored.
- R10: PPU accesses with A13 set go to nametable RAM, with the write enable following PPU writes. Its A10 is PPU A10 when invert is 1 and PPU A11 when invert is 0.
- R11: After reset every register is zero. The mirroring then takes A10 from PPU A11, the bank is 0 and a window read returns zero in bits 5:0.
- R12: Writes below 0x8000 outside the window change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; a write is applied at its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_open_bus | input | 8 | Last value seen on the CPU bus |
| prg_rom_data | input | 8 | Data returned by program ROM |
| cpu_rdata | output | 8 | Data driven back to the CPU |
| prg_addr | output | 15 | Program ROM address |
| prg_oe | output | 1 | Program ROM read enable |
| ppu_addr | input | 14 | PPU address |
| ppu_rd | input | 1 | PPU read strobe |
| ppu_wr | input | 1 | PPU write strobe |
| chr_addr | output | 15 | Character ROM address |
| chr_oe | output | 1 | Character ROM read enable |
| ciram_a10 | output | 1 | Nametable RAM address bit 10 |
| ciram_ce | output | 1 | Nametable RAM select |
| ciram_we | output | 1 | Nametable RAM write enable |

## Verification
The read data, the program ROM enables and all PPU-side outputs are combinational, so they are due in the same cycle that the inputs are presented. A write changes the stored state at the rising edge that ends its cycle, so its effect first shows in the next cycle. The bench drives each cycle's inputs at the falling edge and compares every output shortly after, against a behavioural model that still holds the state from before the write. It applies the write to the model only after the following rising edge, which keeps model and design aligned on each clock.

// File: rtl/revbus_pkg.sv
package revbus_pkg;

    localparam int CORE_W = 6;
    localparam int LO_W   = 4;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_REG_WRITE,
        ACC_REG_READ,
        ACC_ROM_WRITE,
        ACC_ROM_READ,
        ACC_OPEN_READ,
        ACC_DROP_WRITE
    } acc_kind_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_STEP,
        CMD_SET_INV,
        CMD_STAGE,
        CMD_SET_MODE,
        CMD_LATCH
    } core_cmd_e;

    // mirror the order of a CORE_W-bit value
    function automatic logic [CORE_W-1:0] flip_bits(input logic [CORE_W-1:0] v);
        logic [CORE_W-1:0] r;
        for (int i = 0; i < CORE_W; i++) begin
            r[CORE_W-1-i] = v[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/revbus_decode.sv
module revbus_decode
    import revbus_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] WIN_MASK  = 16'hE100,
    parameter logic [15:0] WIN_MATCH = 16'h4100
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output acc_kind_e         kind,
    output core_cmd_e         cmd
);

    logic in_window;
    logic upper_half;

    assign in_window  = ((addr & WIN_MASK) == WIN_MATCH);
    assign upper_half = addr[ADDR_W-1];

    // classify the access; a write wins over a read
    always_comb begin
        if (wr) begin
            if (in_window)       kind = ACC_REG_WRITE;
            else if (upper_half) kind = ACC_ROM_WRITE;
            else                 kind = ACC_DROP_WRITE;
        end else if (rd) begin
            if (in_window)       kind = ACC_REG_READ;
            else if (upper_half) kind = ACC_ROM_READ;
            else                 kind = ACC_OPEN_READ;
        end else begin
            kind = ACC_IDLE;
        end
    end

    // turn the class into a chip command
    always_comb begin
        unique case (kind)
            ACC_REG_WRITE: begin
                unique case (addr[1:0])
                    2'd0:    cmd = CMD_STEP;
                    2'd1:    cmd = CMD_SET_INV;
                    2'd2:    cmd = CMD_STAGE;
                    default: cmd = CMD_SET_MODE;
                endcase
            end
            ACC_ROM_WRITE: cmd = CMD_LATCH;
            default:       cmd = CMD_NONE;
        endcase
    end

endmodule

// File: rtl/revbus_core.sv
module revbus_core
    import revbus_pkg::*;
#(
    parameter int W    = CORE_W,
    parameter int LO   = LO_W,
    localparam int HI  = W - LO
) (
    input  logic         clk,
    input  logic         rst_n,
    input  core_cmd_e    cmd,
    input  logic [W-1:0] din,
    output logic [W-1:0] acc_q,
    output logic         inv_q,
    output logic         inc_q,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] view
);

    logic [LO-1:0] stage_q;
    logic [LO-1:0] acc_lo;
    logic [HI-1:0] acc_hi;
    logic [HI-1:0] hi_seen;

    assign acc_lo  = acc_q[LO-1:0];
    assign acc_hi  = acc_q[W-1:LO];
    assign hi_seen = acc_hi ^ {HI{inv_q}};
    assign view    = {hi_seen, acc_lo};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            stage_q <= '0;
            inv_q   <= 1'b0;
            inc_q   <= 1'b0;
            latch_q <= '0;
        end else begin
            unique case (cmd)
                CMD_STEP: begin
                    if (inc_q) acc_q[LO-1:0] <= acc_lo + 1'b1;
                    else       acc_q[LO-1:0] <= stage_q ^ {LO{inv_q}};
                end
                CMD_SET_INV:  inv_q <= din[0];
                CMD_STAGE: begin
                    acc_q[W-1:LO] <= din[W-1:LO];
                    stage_q       <= din[LO-1:0];
                end
                CMD_SET_MODE: inc_q   <= din[0];
                CMD_LATCH:    latch_q <= view;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/revbus_ppu_route.sv
module revbus_ppu_route #(
    parameter int  PPU_W  = 14,
    parameter int  BANK_W = 2,
    localparam int OFS_W  = PPU_W - 1,
    localparam int CHR_W  = BANK_W + OFS_W
) (
    input  logic [PPU_W-1:0]  ppu_addr,
    input  logic              ppu_rd,
    input  logic              ppu_wr,
    input  logic [BANK_W-1:0] bank,
    input  logic              inv,
    output logic [CHR_W-1:0]  chr_addr,
    output logic              chr_oe,
    output logic              ciram_a10,
    output logic              ciram_ce,
    output logic              ciram_we
);

    logic table_hit;

    assign table_hit = ppu_addr[PPU_W-1];
    assign chr_addr  = {bank, ppu_addr[OFS_W-1:0]};

    always_comb begin
        chr_oe    = ppu_rd & ~table_hit;
        ciram_ce  = (ppu_rd | ppu_wr) & table_hit;
        ciram_we  = ppu_wr & table_hit;
        ciram_a10 = inv ? ppu_addr[10] : ppu_addr[11];
    end

endmodule

// File: rtl/revbus_mapper.sv
module revbus_mapper
    import revbus_pkg::*;
#(
    parameter int  ADDR_W = 16,
    parameter int  DATA_W = 8,
    parameter int  PPU_W  = 14,
    parameter int  BANK_W = 2,
    localparam int PRG_W  = ADDR_W - 1,
    localparam int CHR_W  = BANK_W + PPU_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_open_bus,
    input  logic [DATA_W-1:0] prg_rom_data,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [PRG_W-1:0]  prg_addr,
    output logic              prg_oe,
    input  logic [PPU_W-1:0]  ppu_addr,
    input  logic              ppu_rd,
    input  logic              ppu_wr,
    output logic [CHR_W-1:0]  chr_addr,
    output logic              chr_oe,
    output logic              ciram_a10,
    output logic              ciram_ce,
    output logic              ciram_we
);

    acc_kind_e         kind;
    core_cmd_e         cmd;
    logic [CORE_W-1:0] chip_din;
    logic [CORE_W-1:0] core_reg;
    logic              core_inv;
    logic              core_inc;
    logic [CORE_W-1:0] core_latch;
    logic [CORE_W-1:0] core_view;

    revbus_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr (cpu_addr),
        .wr   (cpu_wr),
        .rd   (cpu_rd),
        .kind (kind),
        .cmd  (cmd)
    );

    // the data lines arrive at the chip in reverse order
    assign chip_din = flip_bits(cpu_wdata[CORE_W-1:0]);

    revbus_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .din     (chip_din),
        .acc_q   (core_reg),
        .inv_q   (core_inv),
        .inc_q   (core_inc),
        .latch_q (core_latch),
        .view    (core_view)
    );

    revbus_ppu_route #(
        .PPU_W  (PPU_W),
        .BANK_W (BANK_W)
    ) u_ppu (
        .ppu_addr  (ppu_addr),
        .ppu_rd    (ppu_rd),
        .ppu_wr    (ppu_wr),
        .bank      (core_latch[BANK_W-1:0]),
        .inv       (core_inv),
        .chr_addr  (chr_addr),
        .chr_oe    (chr_oe),
        .ciram_a10 (ciram_a10),
        .ciram_ce  (ciram_ce),
        .ciram_we  (ciram_we)
    );

    assign prg_addr = cpu_addr[PRG_W-1:0];

    always_comb begin
        prg_oe    = 1'b0;
        cpu_rdata = cpu_open_bus;
        unique case (kind)
            ACC_REG_READ: cpu_rdata = {cpu_open_bus[DATA_W-1:CORE_W], flip_bits(core_view)};
            ACC_ROM_READ: begin
                prg_oe    = 1'b1;
                cpu_rdata = prg_rom_data;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/revbus_mapper_chk.sv
module revbus_mapper_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CHR_W  = 15,
    parameter int BANK_W = 2,
    parameter int CORE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [DATA_W-1:0] cpu_open_bus,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              prg_oe,
    input logic [CHR_W-1:0]  chr_addr,
    input logic              chr_oe,
    input logic              ciram_ce,
    input logic [CORE_W-1:0] core_reg,
    input logic              core_inc
);

    logic win;
    assign win = ((cpu_addr & 16'hE100) == 16'h4100);

    // R7: the bank bits move only after an upper-half write
    a_r7_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr[ADDR_W-1]) |=> $stable(chr_addr[CHR_W-1:CHR_W-BANK_W]));

    // R4: step mode advances the low nibble by one, wrapping
    a_r4_step_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && win && cpu_addr[1:0] == 2'd0 && core_inc)
        |=> core_reg[3:0] == $past(core_reg[3:0]) + 4'd1);

    // R6: window reads keep the open-bus top bits
    a_r6_open_top: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && win)
        |-> cpu_rdata[DATA_W-1:CORE_W] == cpu_open_bus[DATA_W-1:CORE_W]);

    // R8: program ROM enable only for upper-half reads
    a_r8_prg_upper_read: assert property (@(posedge clk) disable iff (!rst_n)
        prg_oe |-> (cpu_addr[ADDR_W-1] && cpu_rd && !cpu_wr));

    // R10: pattern ROM and nametable RAM never selected together
    a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        !(chr_oe && ciram_ce));

endmodule

bind revbus_mapper revbus_mapper_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CHR_W  (CHR_W),
    .BANK_W (BANK_W),
    .CORE_W (revbus_pkg::CORE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_addr     (cpu_addr),
    .cpu_wr       (cpu_wr),
    .cpu_rd       (cpu_rd),
    .cpu_open_bus (cpu_open_bus),
    .cpu_rdata    (cpu_rdata),
    .prg_oe       (prg_oe),
    .chr_addr     (chr_addr),
    .chr_oe       (chr_oe),
    .ciram_ce     (ciram_ce),
    .core_reg     (core_reg),
    .core_inc     (core_inc)
);

// File: tb/revbus_mapper_tb.sv
module revbus_mapper_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_wr;
    logic        cpu_rd;
    logic [7:0]  cpu_open_bus;
    logic [7:0]  prg_rom_data;
    logic [7:0]  cpu_rdata;
    logic [14:0] prg_addr;
    logic        prg_oe;
    logic [13:0] ppu_addr;
    logic        ppu_rd;
    logic        ppu_wr;
    logic [14:0] chr_addr;
    logic        chr_oe;
    logic        ciram_a10;
    logic        ciram_ce;
    logic        ciram_we;

    always #(CLK_PERIOD/2) clk = ~clk;

    revbus_mapper u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_wr       (cpu_wr),
        .cpu_rd       (cpu_rd),
        .cpu_open_bus (cpu_open_bus),
        .prg_rom_data (prg_rom_data),
        .cpu_rdata    (cpu_rdata),
        .prg_addr     (prg_addr),
        .prg_oe       (prg_oe),
        .ppu_addr     (ppu_addr),
        .ppu_rd       (ppu_rd),
        .ppu_wr       (ppu_wr),
        .chr_addr     (chr_addr),
        .chr_oe       (chr_oe),
        .ciram_a10    (ciram_a10),
        .ciram_ce     (ciram_ce),
        .ciram_we     (ciram_we)
    );

    int checks   = 0;
    int failures = 0;

    // behavioural model state
    int m_lo, m_hi, m_stage, m_inv, m_inc, m_out;

    function automatic int rev6(input int v);
        int r = 0;
        for (int i = 0; i < 6; i++) if ((v >> i) & 1) r |= 1 << (5 - i);
        return r;
    endfunction

    function automatic int shown();
        return (((m_hi ^ (m_inv ? 3 : 0)) & 3) << 4) | m_lo;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_lo = 0; m_hi = 0; m_stage = 0; m_inv = 0; m_inc = 0; m_out = 0;
    endtask

    // R2 R3 R4 R5 R7 R12: state changes applied after the write edge
    task automatic model_write(input int a, input int d);
        int cd = rev6(d & 8'h3F);
        if ((a & 16'hE100) == 16'h4100) begin
            case (a & 3)
                0: m_lo = m_inc ? ((m_lo + 1) & 15) : ((m_stage ^ (m_inv ? 15 : 0)) & 15);
                1: m_inv = cd & 1;
                2: begin m_hi = (cd >> 4) & 3; m_stage = cd & 15; end
                default: m_inc = cd & 1;
            endcase
        end else if (a >= 16'h8000) begin
            m_out = shown();
        end
    endtask

    task automatic compare();
        bit win = ((cpu_addr & 16'hE100) == 16'h4100);
        bit rd  = cpu_rd && !cpu_wr;
        int exp_rd;
        bit exp_prg = rd && cpu_addr[15];
        if (rd && win)          exp_rd = (cpu_open_bus & 8'hC0) | rev6(shown());
        else if (exp_prg)       exp_rd = prg_rom_data;
        else                    exp_rd = cpu_open_bus;
        if (rd && win) check("R6", "cpu_rdata", cpu_rdata, exp_rd);
        else           check("R8", "cpu_rdata", cpu_rdata, exp_rd);
        check("R8", "prg_oe", prg_oe, exp_prg);
        if (exp_prg) check("R8", "prg_addr", prg_addr, cpu_addr[14:0]);
        check("R9", "chr_addr", chr_addr, ((m_out & 3) << 13) | ppu_addr[12:0]);
        check("R9", "chr_oe", chr_oe, ppu_rd && !ppu_addr[13]);
        check("R10", "ciram_ce", ciram_ce, (ppu_rd || ppu_wr) && ppu_addr[13]);
        check("R10", "ciram_we", ciram_we, ppu_wr && ppu_addr[13]);
        check("R10", "ciram_a10", ciram_a10, m_inv ? ppu_addr[10] : ppu_addr[11]);
    endtask

    task automatic cyc(input logic [15:0] a, input logic [7:0] d, input bit wr, input bit rd,
                       input logic [13:0] pa, input bit prd, input bit pwr);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = wr; cpu_rd = rd;
        ppu_addr = pa; ppu_rd = prd; ppu_wr = pwr;
        cpu_open_bus = 8'($urandom);
        prg_rom_data = 8'($urandom);
        #1;
        compare();
        @(posedge clk);
        if (wr && rst_n) model_write(a, d);
    endtask

    task automatic wr_cpu(input logic [15:0] a, input logic [7:0] d);
        cyc(a, d, 1'b1, 1'b0, 14'h0000, 1'b0, 1'b0);
    endtask

    task automatic rd_cpu(input logic [15:0] a);
        cyc(a, 8'h00, 1'b0, 1'b1, 14'h0000, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired before the sequence ended");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        cpu_addr = '0; cpu_wdata = '0; cpu_wr = 1'b0; cpu_rd = 1'b0;
        cpu_open_bus = '0; prg_rom_data = '0;
        ppu_addr = '0; ppu_rd = 1'b0; ppu_wr = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state visible at the ports
        rd_cpu(16'h4100);
        cyc(16'h0000, 8'h00, 1'b0, 1'b0, 14'h2C00, 1'b1, 1'b0);
        cyc(16'h0000, 8'h00, 1'b0, 1'b0, 14'h1ABC, 1'b1, 1'b0);

        // R5 R2: stage high pair and nibble; top CPU bits set must not matter
        wr_cpu(16'h4102, 8'hE5);
        rd_cpu(16'h4102);
        // R3: load with invert off
        wr_cpu(16'h4100, 8'h00);
        rd_cpu(16'h4100);
        // R5: invert on via CPU D5 -> chip bit 0
        wr_cpu(16'h4101, 8'h20);
        rd_cpu(16'h4101);
        // R3: load with invert on
        wr_cpu(16'h4100, 8'hFF);
        rd_cpu(16'h4103);
        // R7: latch on upper-half write, bank visible
        wr_cpu(16'h8000, 8'h55);
        cyc(16'h0000, 8'h00, 1'b0, 1'b0, 14'h0123, 1'b1, 1'b0);
        // R10: mirroring with invert on, nametable write
        cyc(16'h0000, 8'h00, 1'b0, 1'b0, 14'h2400, 1'b0, 1'b1);
        cyc(16'h0000, 8'h00, 1'b0, 1'b0, 14'h2800, 1'b1, 1'b0);
        // R9: pattern write ignored
        cyc(16'h0000, 8'h00, 1'b0, 1'b0, 14'h0456, 1'b0, 1'b1);
        // R1: aliased window address 0x5F01 clears invert
        wr_cpu(16'h5F01, 8'h00);
        cyc(16'h0000, 8'h00, 1'b0, 1'b0, 14'h2400, 1'b1, 1'b0);
        cyc(16'h0000, 8'h00, 1'b0, 1'b0, 14'h2800, 1'b1, 1'b0);
        // R12: writes outside the window below 0x8000 are dropped
        wr_cpu(16'h4000, 8'h3F);
        wr_cpu(16'h6000, 8'h3F);
        wr_cpu(16'h4200, 8'h3F);
        rd_cpu(16'h4100);
        // R8: open-bus and ROM reads
        rd_cpu(16'h6123);
        rd_cpu(16'hC321);
        rd_cpu(16'hFFFF);
        // R4: increment mode, step past the wrap
        wr_cpu(16'h4103, 8'h20);
        for (int i = 0; i < 18; i++) begin
            wr_cpu(16'h4100, 8'h00);
            rd_cpu(16'h4100);
        end
        wr_cpu(16'hA000, 8'h00);
        cyc(16'h0000, 8'h00, 1'b0, 1'b0, 14'h1FFF, 1'b1, 1'b0);

        // mixed traffic over all classes
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            case ($urandom_range(0, 4))
                0: a = 16'h4100 | 16'($urandom_range(0, 3)) | (16'($urandom_range(0, 1)) << 12);
                1: a = 16'h8000 | 16'($urandom);
                2: a = 16'($urandom) & 16'h7FFF;
                default: a = 16'h4100 | 16'($urandom_range(0, 3));
            endcase
            cyc(a, 8'($urandom), 1'($urandom), 1'($urandom), 14'($urandom),
                1'($urandom), 1'($urandom));
        end

        finish_run();
    end

endmodule